// File: doc/BRIEF.md
# Buffered Serial Receiver with Flow Control

This block is the receive half of one asynchronous serial channel. It watches the incoming line, recognises start bits, rebuilds characters of 5 to 8 data bits with an optional parity bit, and checks the stop bit. Finished characters are kept in a short queue. Each queued entry carries its own parity and framing flags, and the host drains the queue by pulsing a read strobe while it looks at the head entry.

Timing comes from a sixteen-times enable tick supplied by a baud generator outside the block. A select input can switch the block to a one-times receive clock instead, and that clock's rising edges mark the sample points. The block reports overrun, detects line breaks that may start partway through a character, and discards start pulses that are too short. It can raise an active-low request-to-send output to stop the far end while the queue is full. A multidrop wake-up mode drops every character until one arrives that is marked as an address.

Top module: `serial_rx_buffer`

## Requirements
- R1: The line idles high and a character is a low start bit, then data bits least significant bit first, then one stop bit. In tick mode (clk_sel=0) the start bit is confirmed on the 8th tick after the first low tick is seen, and each later bit is sampled every 16 ticks after that.
- R2: cfg_len selects the data length: 00=5, 01=6, 10=7, 11=8 bits. Received data is right-aligned in rx_data and the unused upper bits read 0.
- R3: par_mode selects the parity: 00=none, 01=even, 10=odd, 11=forced to the value of par_force. When a parity bit is present and does not match, err_par is set for that entry.
- R4: A stop bit sampled low sets err_frm for that entry. rx_data, err_par and err_frm always describe the head of the queue, and all three read 0 when the queue is empty.
- R5: A start bit that is high again at its confirmation point is discarded, and the receiver goes back to watching for a start bit without storing anything.
- R6: The block holds HOLD (default 3) entries in the queue plus one more waiting in the shift stage. rdy is 1 while at least one entry is queued, and full is 1 while all HOLD holding entries are occupied. A rd pulse removes the head entry. A waiting character moves into the queue as soon as there is room, and characters leave the queue in the order they arrived.
- R7: If a character completes while the queue is full and a character is already waiting, ovr is set and the new character replaces the waiting one. ovr stays set until a clr_err pulse clears it.
- R8: rts_n is 1 while rts_auto=1 and full=1. Otherwise rts_n is 0.
- R9: flag_n is the inverse of rdy when flag_sel=0 and the inverse of full when flag_sel=1.
- R10: After a framing error, if the line is still low half a bit time later, brk_active becomes 1. It returns to 0 once the line is seen high again. Each of these two changes produces a one-cycle brk_evt pulse, and only the single framing-error character is stored for the whole break.
- R11: With wake_en=1 a bit always occupies the parity slot and acts as the address mark. While the receiver is asleep, only characters whose mark is 1 are stored. Storing such a character wakes the receiver, and after that all characters are stored. Taking wake_en to 0 puts the receiver back to sleep. In wake-up mode err_par reports the address mark of the entry.
- R12: With clk_sel=1 the line is sampled at each rising edge of rx_clk1x. The first low sample counts as the start bit, and each following rising edge samples the next bit.
- R13: After reset: rdy=0, full=0, ovr=0, brk_active=0, brk_evt=0, rts_n=0 and flag_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Sixteen-times bit-rate enable |
| clk_sel | input | 1 | 0: use tick16, 1: use rx_clk1x |
| rx_clk1x | input | 1 | External one-times receive clock |
| rxd | input | 1 | Serial line input |
| cfg_len | input | 2 | Data length code |
| par_mode | input | 2 | Parity mode code |
| par_force | input | 1 | Parity value expected in forced mode |
| wake_en | input | 1 | Multidrop wake-up mode |
| rts_auto | input | 1 | Automatic request-to-send control |
| flag_sel | input | 1 | Chooses rdy or full for flag_n |
| rd | input | 1 | Remove head entry |
| clr_err | input | 1 | Clear the overrun flag |
| rx_data | output | 8 | Head entry data |
| rdy | output | 1 | Queue not empty |
| full | output | 1 | Holding entries all occupied |
| err_par | output | 1 | Head entry parity error or address mark |
| err_frm | output | 1 | Head entry framing error |
| ovr | output | 1 | Sticky overrun |
| brk_active | output | 1 | Break in progress |
| brk_evt | output | 1 | Break start or end pulse |
| rts_n | output | 1 | Request to send, active low |
| flag_n | output | 1 | Selected status, active low |

## Verification
If the bit counter or the sample phase slips, the head entry arrives with shifted data or a false framing flag. That shows at rx_data and err_frm one bit time after the stop bit. If the queue pointers or the waiting slot are corrupted, characters come out duplicated, missing or in the wrong order when the queue is drained, and full, rts_n and ovr change at the wrong character while the queue is being filled. A fault in the break or wake-up state shows either as extra stored entries or extra brk_evt pulses within a few bit times of the line change, or as a character that is expected and never appears.

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer #(
  parameter int HOLD = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       clk_sel,
  input  logic       rx_clk1x,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic [1:0] par_mode,
  input  logic       par_force,
  input  logic       wake_en,
  input  logic       rts_auto,
  input  logic       flag_sel,
  input  logic       rd,
  input  logic       clr_err,
  output logic [7:0] rx_data,
  output logic       rdy,
  output logic       full,
  output logic       err_par,
  output logic       err_frm,
  output logic       ovr,
  output logic       brk_active,
  output logic       brk_evt,
  output logic       rts_n,
  output logic       flag_n
);
  localparam int PW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int CW = $clog2(HOLD + 1);
  localparam int EW = 10;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BCHK, S_BRK} st_t;

  st_t          st;
  logic [3:0]   ph;
  logic [2:0]   bi;
  logic [7:0]   sh;
  logic         pbit, awake, c1q;

  logic [EW-1:0] mem [HOLD];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [EW-1:0] pend;
  logic          pv;

  wire rise   = rx_clk1x & ~c1q;
  wire bit_ev = clk_sel ? rise : tick16;
  wire half   = (st == S_START) || (st == S_BCHK);
  wire samp   = clk_sel ? rise : (tick16 && ph == (half ? 4'd7 : 4'd15));
  wire [2:0] last = {1'b0, cfg_len} + 3'd4;
  wire slot   = wake_en || (par_mode != 2'b00);

  wire stop_now = (st == S_STOP) && samp;
  wire ones     = ^sh;
  logic pe;
  always_comb begin
    if (wake_en) pe = pbit;
    else case (par_mode)
      2'b01:   pe = ones ^ pbit;
      2'b10:   pe = ~(ones ^ pbit);
      2'b11:   pe = pbit ^ par_force;
      default: pe = 1'b0;
    endcase
  end

  wire           push   = stop_now && (!wake_en || awake || pbit);
  wire [EW-1:0]  newent = {~rxd, pe, sh};

  always_ff @(posedge clk) begin
    c1q     <= rx_clk1x;
    brk_evt <= 1'b0;
    if (rst) begin
      st    <= S_IDLE;
      ph    <= 4'd0;
      bi    <= 3'd0;
      sh    <= 8'd0;
      pbit  <= 1'b0;
      awake <= 1'b0;
      c1q   <= 1'b0;
    end else begin
      if (!clk_sel && tick16) ph <= samp ? 4'd0 : ph + 4'd1;
      awake <= wake_en && (awake || (stop_now && pbit));
      case (st)
        S_IDLE:
          if (bit_ev && !rxd) begin
            ph   <= 4'd0;
            bi   <= 3'd0;
            sh   <= 8'd0;
            pbit <= 1'b0;
            st   <= clk_sel ? S_DATA : S_START;
          end
        S_START:
          if (samp) st <= rxd ? S_IDLE : S_DATA;
        S_DATA:
          if (samp) begin
            sh[bi] <= rxd;
            bi     <= bi + 3'd1;
            if (bi == last) st <= slot ? S_PAR : S_STOP;
          end
        S_PAR:
          if (samp) begin
            pbit <= rxd;
            st   <= S_STOP;
          end
        S_STOP:
          if (samp) st <= rxd ? S_IDLE : S_BCHK;
        S_BCHK:
          if (bit_ev && rxd) st <= S_IDLE;
          else if (samp) begin
            st      <= S_BRK;
            brk_evt <= 1'b1;
          end
        S_BRK:
          if (bit_ev && rxd) begin
            st      <= S_IDLE;
            brk_evt <= 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire           pop   = rd && (cnt != '0);
  wire           room  = (cnt != CW'(HOLD)) || pop;
  wire           mv    = pv && pop;
  wire           wr    = mv || (push && room && !pv);
  wire [EW-1:0]  wdat  = pv ? pend : newent;
  wire           spill = push && !room;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdat;
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      pv   <= 1'b0;
      pend <= '0;
      ovr  <= 1'b0;
    end else begin
      if (wr)  wp <= (wp == PW'(HOLD - 1)) ? '0 : wp + PW'(1);
      if (pop) rp <= (rp == PW'(HOLD - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(wr) - CW'(pop);
      if (mv) begin
        pv <= push;
        if (push) pend <= newent;
      end else if (spill) begin
        pv   <= 1'b1;
        pend <= newent;
      end
      if (spill && pv) ovr <= 1'b1;
      else if (clr_err) ovr <= 1'b0;
    end
  end

  wire [EW-1:0] head = mem[rp];
  assign rdy        = (cnt != '0);
  assign full       = (cnt == CW'(HOLD));
  assign rx_data    = rdy ? head[7:0] : 8'd0;
  assign err_par    = rdy & head[8];
  assign err_frm    = rdy & head[9];
  assign brk_active = (st == S_BRK);
  assign rts_n      = rts_auto & full;
  assign flag_n     = ~(flag_sel ? full : rdy);
endmodule

// File: rtl/serial_rx_buffer_chk.sv
module serial_rx_buffer_chk (
  input logic clk,
  input logic rst,
  input logic rd,
  input logic clr_err,
  input logic rdy,
  input logic full,
  input logic ovr,
  input logic brk_active,
  input logic brk_evt
);
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst) full |-> rdy); // R6
  AST_DATA_KEPT: assert property (@(posedge clk) disable iff (rst) rdy && !rd |=> rdy); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) ovr && !clr_err |=> ovr); // R7
  AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) $rose(ovr) |-> $past(full)); // R7
  AST_BRK_EVENT: assert property (@(posedge clk) disable iff (rst) (brk_active != $past(brk_active)) |-> brk_evt); // R10
endmodule

bind serial_rx_buffer serial_rx_buffer_chk u_chk (.*);

// File: tb/serial_rx_buffer_test.sv
`timescale 1ns/100ps
module serial_rx_buffer_test;
  logic clk = 0, rst = 1, tick16, clk_sel = 0, rx_clk1x = 0, rxd = 1;
  logic [1:0] cfg_len = 2'b11, par_mode = 2'b00;
  logic par_force = 0, wake_en = 0, rts_auto = 0, flag_sel = 0, rd = 0, clr_err = 0;
  logic [7:0] rx_data;
  logic rdy, full, err_par, err_frm, ovr, brk_active, brk_evt, rts_n, flag_n;
  logic [1:0] td = 0;
  int nchk = 0, nfail = 0, nbrk = 0;
  bit auto_rd = 1, done = 0;
  logic [9:0] exq[$];
  string tagq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) td <= td + 2'd1;
  assign tick16 = (td == 2'd0);

  serial_rx_buffer uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input logic fe, input logic pe, input logic [7:0] d, input string tag);
    exq.push_back({fe, pe, d});
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (brk_evt) nbrk++;
    if (rd) rd = 0;
    else if (auto_rd && rdy && !rst) begin
      if (exq.size() == 0) chk(0, "R6 unexpected entry", {err_frm, err_par, rx_data}, 0);
      else begin
        logic [9:0] e;
        string t;
        e = exq.pop_front();
        t = tagq.pop_front();
        chk({err_frm, err_par, rx_data} == e, t, {err_frm, err_par, rx_data}, e);
      end
      rd = 1;
    end
  end

  task automatic one_bit(input logic v);
    if (clk_sel) begin
      @(negedge clk) rxd = v;
      repeat (8) @(negedge clk);
      rx_clk1x = 1;
      repeat (8) @(negedge clk);
      rx_clk1x = 0;
    end else begin
      @(negedge clk) rxd = v;
      repeat (63) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit hp, input logic pb, input logic sb);
    one_bit(0);
    for (int i = 0; i < nb; i++) one_bit(d[i]);
    if (hp) one_bit(pb);
    one_bit(sb);
    one_bit(1);
  endtask

  task automatic drain;
    auto_rd = 1;
    for (int i = 0; i < 2000 && (exq.size() != 0 || rdy); i++) @(negedge clk);
    chk(exq.size() == 0, "R6 queue drained", exq.size(), 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({rdy, full, ovr, brk_active, brk_evt, rts_n, flag_n} == 7'b0000001, "R13 reset state",
        {rdy, full, ovr, brk_active, brk_evt, rts_n, flag_n}, 7'b0000001);
    repeat (64) @(negedge clk);

    expect_item(0, 0, 8'hA5, "R1 8-bit no parity A5");
    send(8'hA5, 8, 0, 0, 1);
    cfg_len = 2'b10; par_mode = 2'b01;
    expect_item(0, 0, 8'h35, "R3 even parity good");
    send(8'h35, 7, 1, 0, 1);
    expect_item(0, 1, 8'h35, "R3 even parity bad");
    send(8'h35, 7, 1, 1, 1);
    cfg_len = 2'b00; par_mode = 2'b10;
    expect_item(0, 0, 8'h13, "R2 5-bit odd parity good");
    send(8'h13, 5, 1, 0, 1);
    cfg_len = 2'b11; par_mode = 2'b11; par_force = 1;
    expect_item(0, 0, 8'h5A, "R3 forced parity match");
    send(8'h5A, 8, 1, 1, 1);
    expect_item(0, 1, 8'h5A, "R3 forced parity mismatch");
    send(8'h5A, 8, 1, 0, 1);
    par_mode = 2'b00;
    expect_item(1, 0, 8'h3C, "R4 framing error entry");
    send(8'h3C, 8, 0, 0, 0);
    drain();
    chk(!brk_active && nbrk == 0, "R10 short low stop is no break", {brk_active, nbrk[7:0]}, 0);
    chk(!rdy && rx_data == 0 && !err_frm, "R4 empty head reads zero", {rdy, err_frm, rx_data}, 0);

    @(negedge clk) rxd = 0;
    repeat (12) @(negedge clk);
    rxd = 1;
    repeat (128) @(negedge clk);
    chk(!rdy, "R5 false start dropped", rdy, 0);
    expect_item(0, 0, 8'h81, "R5 char after false start");
    send(8'h81, 8, 0, 0, 1);
    drain();

    auto_rd = 0; rts_auto = 1; flag_sel = 1;
    send(8'h11, 8, 0, 0, 1);
    chk(rdy && !full && !rts_n && flag_n, "R9 flag_n follows full", {rdy, full, rts_n, flag_n}, 4'b1001);
    send(8'h22, 8, 0, 0, 1);
    send(8'h33, 8, 0, 0, 1);
    chk(full && rts_n && !flag_n, "R8 rts_n high when full", {full, rts_n, flag_n}, 3'b110);
    send(8'h44, 8, 0, 0, 1);
    chk(full && !ovr, "R6 fourth char waits without overrun", {full, ovr}, 2'b10);
    send(8'h55, 8, 0, 0, 1);
    chk(ovr, "R7 overrun on fifth char", ovr, 1);
    expect_item(0, 0, 8'h11, "R6 order 1");
    expect_item(0, 0, 8'h22, "R6 order 2");
    expect_item(0, 0, 8'h33, "R6 order 3");
    expect_item(0, 0, 8'h55, "R7 newest replaces waiting");
    drain();
    chk(!full && !rts_n && ovr, "R7 overrun sticky after drain", {full, rts_n, ovr}, 3'b001);
    @(negedge clk) clr_err = 1;
    @(negedge clk) clr_err = 0;
    chk(!ovr, "R7 clr_err clears overrun", ovr, 0);
    flag_sel = 0; rts_auto = 0;
    @(negedge clk);
    chk(flag_n, "R9 flag_n follows rdy", flag_n, 1);

    expect_item(1, 0, 8'h07, "R10 mid-char break entry");
    one_bit(0); one_bit(1); one_bit(1); one_bit(1);
    @(negedge clk) rxd = 0;
    repeat (30 * 64) @(negedge clk);
    chk(brk_active && nbrk == 1, "R10 break start", {brk_active, nbrk[7:0]}, {1'b1, 8'd1});
    rxd = 1;
    repeat (128) @(negedge clk);
    chk(!brk_active && nbrk == 2, "R10 break end", {brk_active, nbrk[7:0]}, {1'b0, 8'd2});
    drain();

    wake_en = 1;
    send(8'h10, 8, 1, 0, 1);
    chk(!rdy, "R11 data ignored while asleep", rdy, 0);
    expect_item(0, 1, 8'hA1, "R11 address char wakes");
    send(8'hA1, 8, 1, 1, 1);
    expect_item(0, 0, 8'h10, "R11 data accepted when awake");
    send(8'h10, 8, 1, 0, 1);
    drain();
    wake_en = 0;
    @(negedge clk) wake_en = 1;
    send(8'h20, 8, 1, 0, 1);
    chk(!rdy && exq.size() == 0, "R11 asleep again after re-enable", rdy, 0);
    wake_en = 0;

    clk_sel = 1;
    one_bit(1);
    expect_item(0, 0, 8'h6E, "R12 external 1x clock char");
    send(8'h6E, 8, 0, 0, 1);
    drain();

    done = 1;
    summary();
  end
endmodule